// File: doc/BRIEF.md
# Dual-Direction Latch/Register Bus Transceiver

This block sits between two data ports, A and B, and passes data in both directions. Each direction has one storage element per bit. A latch-enable input chooses how that element behaves: it can follow its input, hold its value, or load its input on a rising edge of the direction's own clock input. The stored value is always presented on the opposite port. A separate output-enable vector marks whether the port is driven; an enable of 0 stands for high impedance. The A-to-B enable is active high and the B-to-A enable is active low.

The data path is split into independent halves. Each half has its own six controls: an output enable, a latch enable and a clock input for each direction. All behaviour is sampled on one system clock `clk`. The latch is transparent in the sense that it tracks its input on every sample cycle. The direction clocks are ordinary data inputs, and the block finds their rising edges by sampling them twice.

Top module: `dual_path_xcvr`

## Requirements
- R1: A synchronous reset (`rst_n` low at a `clk` edge) clears both storage elements of every half to zero, so `b_out` and `a_out` read 0 after the edge.
- R2: While `fwd_le[h]` is 1, the B data of half h (bits h*WIDTH to h*WIDTH+WIDTH-1) equals the A input sampled at the most recent `clk` edge, so it is visible one cycle after the input is applied.
- R3: While `fwd_le[h]` is 0 and `fwd_ck[h]` stays steady, whether high or low, the B data of half h keeps its value no matter how `a_in` changes. A falling `fwd_ck[h]` also leaves it unchanged.
- R4: While `fwd_le[h]` is 0, suppose `fwd_ck[h]` is sampled 0 at one `clk` edge and 1 at the next (edge k). Then the storage loads the `a_in` value sampled at edge k+1, and this value is visible after that edge.
- R5: `b_oe` for half h is all ones while `fwd_oe[h]` is 1 and all zeros while it is 0, in the same cycle. The enable never changes the stored data.
- R6: The B-to-A direction follows R2 to R4 with `rev_le`, `rev_ck`, `b_in` and `a_out`.
- R7: `a_oe` for half h is all ones while `rev_oe_n[h]` is 0 and all zeros while it is 1, in the same cycle.
- R8: The controls of one half never affect the data or enables of another half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | HALVES*WIDTH | Data arriving at port A |
| b_in | input | HALVES*WIDTH | Data arriving at port B |
| fwd_oe | input | HALVES | A-to-B output enable, active high |
| fwd_le | input | HALVES | A-to-B latch enable |
| fwd_ck | input | HALVES | A-to-B capture clock |
| rev_oe_n | input | HALVES | B-to-A output enable, active low |
| rev_le | input | HALVES | B-to-A latch enable |
| rev_ck | input | HALVES | B-to-A capture clock |
| b_out | output | HALVES*WIDTH | Data driven onto port B |
| b_oe | output | HALVES*WIDTH | Per-bit drive enable for port B (0 = high impedance) |
| a_out | output | HALVES*WIDTH | Data driven onto port A |
| a_oe | output | HALVES*WIDTH | Per-bit drive enable for port A (0 = high impedance) |

## Verification
The enables respond in the same cycle. Transparent data is due one `clk` edge after it is applied. A captured word is due two edges after the clock input rises: the first edge sees the clock high and the second loads the data. The bench drives every input on the falling edge of `clk`. A behavioural model updates on the rising edge from the same sampled inputs, and the bench compares every output at the next falling edge, so each result is checked in exactly the cycle it is due. Directed checks for reset, follow, hold and capture are placed on that same falling-edge grid.

// File: rtl/xcvr_pkg.sv
// Shared types for the dual-direction transceiver.
package xcvr_pkg;
    // Behaviour of a storage element on one sample cycle
    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_FOLLOW  = 2'd1,
        ST_CAPTURE = 2'd2
    } store_mode_e;
endpackage

// File: rtl/xcvr_edge_sync.sv
// Samples a direction clock input twice and flags its rising edge.
// Assumes: the input changes slowly relative to clk. During reset both
// stages load the live input, so no edge is seen on reset release.
module xcvr_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic ck_in,
    output logic rise_o
);
    logic stage1, stage2;

    // Two-stage sample; reset pre-loads the current level in both stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= ck_in;
            stage2 <= ck_in;
        end else begin
            stage1 <= ck_in;
            stage2 <= stage1;
        end
    end

    // Edge flag: newer sample high, older sample low
    always_comb rise_o = stage1 & ~stage2;

    // R4
    edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/xcvr_store.sv
// One direction's storage: follows din while le is high, loads din on a
// detected clock rise while le is low, and otherwise holds.
// Assumes: rise is a single-cycle pulse from xcvr_edge_sync.
module xcvr_store #(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             le,
    input  logic             rise,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);
    import xcvr_pkg::*;

    store_mode_e mode;

    // Mode select: latch enable has priority over a clock edge
    always_comb begin
        if (le)        mode = ST_FOLLOW;
        else if (rise) mode = ST_CAPTURE;
        else           mode = ST_HOLD;
    end

    // Storage update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            case (mode)
                ST_FOLLOW, ST_CAPTURE: q <= din;
                default:               q <= q;
            endcase
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> q == '0);
    // R2
    follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        le |=> q == $past(din));
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && !rise) |=> q == $past(q));
    // R4
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> q == $past(din));
endmodule

// File: rtl/xcvr_half.sv
// One independent half: an A-to-B and a B-to-A path, each with its own
// edge sampler and storage, plus per-bit drive enables.
// Assumes: the A-to-B enable is active high and the B-to-A enable active low.
module xcvr_half #(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             fwd_oe,
    input  logic             fwd_le,
    input  logic             fwd_ck,
    input  logic             rev_oe_n,
    input  logic             rev_le,
    input  logic             rev_ck,
    output logic [WIDTH-1:0] b_out,
    output logic [WIDTH-1:0] b_oe,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] a_oe
);
    logic fwd_rise, rev_rise;

    xcvr_edge_sync i_fwd_sync (.clk(clk), .rst_n(rst_n), .ck_in(fwd_ck), .rise_o(fwd_rise));
    xcvr_edge_sync i_rev_sync (.clk(clk), .rst_n(rst_n), .ck_in(rev_ck), .rise_o(rev_rise));

    xcvr_store #(.WIDTH(WIDTH)) i_fwd_store (
        .clk(clk), .rst_n(rst_n), .le(fwd_le), .rise(fwd_rise), .din(a_in), .q(b_out));
    xcvr_store #(.WIDTH(WIDTH)) i_rev_store (
        .clk(clk), .rst_n(rst_n), .le(rev_le), .rise(rev_rise), .din(b_in), .q(a_out));

    // Drive enables with opposite polarity per direction
    always_comb begin
        b_oe = {WIDTH{fwd_oe}};
        a_oe = {WIDTH{~rev_oe_n}};
    end
endmodule

// File: rtl/dual_path_xcvr.sv
// Top: HALVES independent transceiver halves of WIDTH bits each.
// Assumes: half h owns bits h*WIDTH +: WIDTH of every data vector.
module dual_path_xcvr #(
    parameter int HALVES = 2,
    parameter int WIDTH  = 18,
    localparam int BUS   = HALVES * WIDTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS-1:0]    a_in,
    input  logic [BUS-1:0]    b_in,
    input  logic [HALVES-1:0] fwd_oe,
    input  logic [HALVES-1:0] fwd_le,
    input  logic [HALVES-1:0] fwd_ck,
    input  logic [HALVES-1:0] rev_oe_n,
    input  logic [HALVES-1:0] rev_le,
    input  logic [HALVES-1:0] rev_ck,
    output logic [BUS-1:0]    b_out,
    output logic [BUS-1:0]    b_oe,
    output logic [BUS-1:0]    a_out,
    output logic [BUS-1:0]    a_oe
);
    // One half per control set
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        xcvr_half #(.WIDTH(WIDTH)) i_half (
            .clk      (clk),
            .rst_n    (rst_n),
            .a_in     (a_in[h*WIDTH +: WIDTH]),
            .b_in     (b_in[h*WIDTH +: WIDTH]),
            .fwd_oe   (fwd_oe[h]),
            .fwd_le   (fwd_le[h]),
            .fwd_ck   (fwd_ck[h]),
            .rev_oe_n (rev_oe_n[h]),
            .rev_le   (rev_le[h]),
            .rev_ck   (rev_ck[h]),
            .b_out    (b_out[h*WIDTH +: WIDTH]),
            .b_oe     (b_oe[h*WIDTH +: WIDTH]),
            .a_out    (a_out[h*WIDTH +: WIDTH]),
            .a_oe     (a_oe[h*WIDTH +: WIDTH])
        );
    end
endmodule

// File: tb/test_dual_path_xcvr.sv
module test_dual_path_xcvr;
    localparam int HALVES = 2;
    localparam int WIDTH  = 18;
    localparam int BUS    = HALVES * WIDTH;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [BUS-1:0] a_in = '0, b_in = '0;
    logic [HALVES-1:0] fwd_oe = '0, fwd_le = '0, fwd_ck = '0;
    logic [HALVES-1:0] rev_oe_n = '1, rev_le = '0, rev_ck = '0;
    logic [BUS-1:0] b_out, b_oe, a_out, a_oe;

    dual_path_xcvr #(.HALVES(HALVES), .WIDTH(WIDTH)) i_dual_path_xcvr (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .fwd_oe(fwd_oe), .fwd_le(fwd_le), .fwd_ck(fwd_ck),
        .rev_oe_n(rev_oe_n), .rev_le(rev_le), .rev_ck(rev_ck),
        .b_out(b_out), .b_oe(b_oe), .a_out(a_out), .a_oe(a_oe));

    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";
    bit model_on = 1'b0;

    // Reference state: stored words and a history of sampled clock levels
    logic [BUS-1:0] m_b = '0, m_a = '0;
    bit fwd_hist[HALVES][$];
    bit rev_hist[HALVES][$];

    task automatic check(string req, string what, logic [BUS-1:0] act, logic [BUS-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Model: on every sampled edge, apply follow / capture / hold per requirement
    always @(posedge clk) begin
        for (int h = 0; h < HALVES; h++) begin
            if (!rst_n) begin
                m_b[h*WIDTH +: WIDTH] = '0;
                m_a[h*WIDTH +: WIDTH] = '0;
                fwd_hist[h] = {fwd_ck[h], fwd_ck[h]};
                rev_hist[h] = {rev_ck[h], rev_ck[h]};
            end else begin
                // R4: clock seen high at previous sample, low at the one before
                if (fwd_le[h] || (fwd_hist[h][0] && !fwd_hist[h][1]))
                    m_b[h*WIDTH +: WIDTH] = a_in[h*WIDTH +: WIDTH];
                if (rev_le[h] || (rev_hist[h][0] && !rev_hist[h][1]))
                    m_a[h*WIDTH +: WIDTH] = b_in[h*WIDTH +: WIDTH];
                fwd_hist[h].push_front(fwd_ck[h]);
                void'(fwd_hist[h].pop_back());
                rev_hist[h].push_front(rev_ck[h]);
                void'(rev_hist[h].pop_back());
            end
        end
    end

    // Compare every cycle at the falling edge
    always @(negedge clk) begin
        if (model_on) begin
            logic [BUS-1:0] eb, ea;
            for (int h = 0; h < HALVES; h++) begin
                eb[h*WIDTH +: WIDTH] = {WIDTH{fwd_oe[h]}};
                ea[h*WIDTH +: WIDTH] = {WIDTH{~rev_oe_n[h]}};
            end
            check(cur_req, "b_out", b_out, m_b);
            check(cur_req, "a_out", a_out, m_a);
            check(cur_req, "b_oe", b_oe, eb);
            check(cur_req, "a_oe", a_oe, ea);
        end
    end

    function automatic logic [BUS-1:0] rnd_bus();
        return {$urandom, $urandom};
    endfunction

    task automatic run();
        logic [BUS-1:0] held;
        // R1: reset with busy inputs
        cur_req = "R1";
        a_in = rnd_bus(); b_in = rnd_bus(); fwd_le = '1; rev_le = '1;
        repeat (3) @(negedge clk);
        fwd_le = '0; rev_le = '0;
        @(negedge clk); rst_n = 1'b1;
        model_on = 1'b1;
        @(negedge clk);
        check("R1", "b_out after reset", b_out, '0);
        check("R1", "a_out after reset", a_out, '0);

        // R5 / R7: enable polarity
        cur_req = "R5"; fwd_oe = '1; @(negedge clk);
        check("R5", "b_oe high", b_oe, '1);
        fwd_oe = 2'b01; @(negedge clk);
        cur_req = "R7"; rev_oe_n = '0; @(negedge clk);
        check("R7", "a_oe low-active", a_oe, '1);
        rev_oe_n = 2'b10; @(negedge clk);

        // R2: follow mode
        cur_req = "R2"; fwd_le = '1;
        for (int i = 0; i < 6; i++) begin
            a_in = (i == 0) ? '1 : (i == 1) ? '0 : rnd_bus();
            @(negedge clk);
            check("R2", "follow", b_out, a_in);
        end

        // R3: hold with clock low, high, and falling
        cur_req = "R3"; fwd_le = '0; @(negedge clk);
        held = b_out;
        for (int i = 0; i < 4; i++) begin a_in = rnd_bus(); @(negedge clk); end
        fwd_ck = '1; @(negedge clk); @(negedge clk);
        held = b_out;
        for (int i = 0; i < 4; i++) begin a_in = rnd_bus(); @(negedge clk); end
        check("R3", "hold clock high", b_out, held);
        fwd_ck = '0;
        for (int i = 0; i < 4; i++) begin a_in = rnd_bus(); @(negedge clk); end
        check("R3", "hold after fall", b_out, held);

        // R4: capture on rise, two sample edges later
        cur_req = "R4";
        fwd_ck = '1; a_in = rnd_bus(); @(negedge clk);
        a_in = 36'h5_A5A5_A5A5; held = a_in; @(negedge clk);
        a_in = rnd_bus(); @(negedge clk);
        check("R4", "captured word", b_out, held);

        // R6: reverse direction follow, hold, capture
        cur_req = "R6"; rev_le = '1;
        for (int i = 0; i < 4; i++) begin b_in = rnd_bus(); @(negedge clk); end
        rev_le = '0;
        for (int i = 0; i < 4; i++) begin b_in = rnd_bus(); @(negedge clk); end
        rev_ck = '1; @(negedge clk);
        for (int i = 0; i < 3; i++) begin b_in = rnd_bus(); @(negedge clk); end
        rev_ck = '0; @(negedge clk);

        // R8: one half follows, the other holds
        cur_req = "R8"; fwd_le = 2'b01; rev_le = 2'b10; fwd_ck = '0; rev_ck = '0;
        @(negedge clk); held = b_out;
        for (int i = 0; i < 5; i++) begin a_in = rnd_bus(); b_in = rnd_bus(); @(negedge clk); end
        check("R8", "upper half held", {b_out[BUS-1:WIDTH], {WIDTH{1'b0}}},
              {held[BUS-1:WIDTH], {WIDTH{1'b0}}});

        // Random mix of all modes, with occasional reset (R8 independence)
        for (int i = 0; i < 3000; i++) begin
            a_in = rnd_bus(); b_in = rnd_bus();
            fwd_oe = 2'($urandom); rev_oe_n = 2'($urandom);
            if ($urandom_range(3) == 0) fwd_le = 2'($urandom);
            if ($urandom_range(3) == 0) rev_le = 2'($urandom);
            if ($urandom_range(2) == 0) fwd_ck = 2'($urandom);
            if ($urandom_range(2) == 0) rev_ck = 2'($urandom);
            rst_n = ($urandom_range(199) != 0);
            @(negedge clk);
        end
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        fwd_hist[0] = {1'b0, 1'b0}; fwd_hist[1] = {1'b0, 1'b0};
        rev_hist[0] = {1'b0, 1'b0}; rev_hist[1] = {1'b0, 1'b0};
        @(negedge clk);
        fork
            run();
            begin
                repeat (50000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule